// File: doc/BRIEF.md
# ALU with Condition-Code Flags

This block is the execute-stage arithmetic/logic unit of a small 32-bit processor core. It takes two operands and a 4-bit operation code and returns the result in the same cycle, with no register in that path. There are four operations: add, subtract, bitwise AND and bitwise XOR. When the instruction is an operate instruction, the caller raises the set-flags enable. The overflow, sign and zero flags of that result are then registered on the next rising clock edge.

A combinational evaluator reads the stored flags and a 4-bit jump condition code, and reports whether a branch should be taken. Moves, jumps, calls and stack operations keep the set-flags enable low, so the flags left by the last operate instruction stay in place. An operation code outside the four defined codes raises an error output and does not touch the flags.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation code 0 gives result = A + B modulo 2^32, combinationally, in the same cycle. The add is the same for signed and unsigned operands.
- R2: Operation code 1 gives result = B - A modulo 2^32, combinationally.
- R3: Operation code 2 gives result = A & B, and operation code 3 gives result = A ^ B, both combinationally.
- R4: Operation codes 4 to 15 drive the error output high and the result to zero, and leave the flags unchanged even when the set-flags enable is high. Codes 0 to 3 keep the error output low.
- R5: The flags output packs OF in bit 2, SF in bit 1 and ZF in bit 0. When the set-flags enable is high with a defined code, ZF is set to (result == 0) and SF is set to result bit 31, both taking effect at the next rising clock edge.
- R6: On add, OF is set when A and B have the same sign and the result's sign differs from theirs. On subtract, OF is set when A and B differ in sign and the result's sign differs from B's. AND and XOR clear OF.
- R7: While the set-flags enable is low, the flags keep their value across clock edges.
- R8: While reset is asserted, and after it is released, the flags read ZF=1, SF=0, OF=0 (flags output 3'b001) until the first update.
- R9: The branch-taken output decodes the stored flags by jump code. The codes are: 0 always; 1 (SF^OF)|ZF; 2 SF^OF; 3 ZF; 4 ~ZF; 5 ~(SF^OF); 6 ~(SF^OF)&~ZF. Codes 7 to 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | Operand A (source register value) |
| b_i | input | 32 | Operand B (destination register value) |
| alu_fn_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Capture this result's flags at the next edge |
| jmp_fn_i | input | 4 | Jump condition code |
| result_o | output | 32 | Operation result |
| fn_err_o | output | 1 | Undefined operation code |
| flags_o | output | 3 | Stored flags {OF, SF, ZF} |
| take_o | output | 1 | Branch condition is met by the stored flags |

## Verification
The result and the error output are combinational. The bench therefore samples them 1 ns after it drives the operands, inside the same cycle. The flags pass through one register, so they are checked 1 ns after the rising edge that follows the stimulus, and they are compared with a value predicted from the operands of the cycle before. The branch-taken output depends only on the stored flags and the jump code. All sixteen jump codes are swept in short steps after each flag update, and all of these samples fall before the next falling edge, where new stimulus is applied.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    JC_ALW = 4'd0,
    JC_LE  = 4'd1,
    JC_LT  = 4'd2,
    JC_EQ  = 4'd3,
    JC_NE  = 4'd4,
    JC_GE  = 4'd5,
    JC_GT  = 4'd6
  } jmp_fn_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
  } flags_t;

  localparam flags_t FLAGS_RST = '{of: 1'b0, sf: 1'b0, zf: 1'b1};
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic         of_o,
  output logic         err_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum, diff;
  assign sum  = b_i + a_i;
  assign diff = b_i - a_i;

  always_comb begin
    res_o = '0;
    of_o  = 1'b0;
    err_o = 1'b0;
    case (fn_i)
      FN_ADD: begin
        res_o = sum;
        of_o  = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      FN_SUB: begin
        res_o = diff;
        of_o  = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != b_i[MSB]);
      end
      FN_AND: res_o = a_i & b_i;
      FN_XOR: res_o = a_i ^ b_i;
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_cc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= FLAGS_RST;
    else if (en_i) q_o <= d_i;
  end

  // R7
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cc_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] jmp_i,
  output logic       take_o
);
  logic lt;
  assign lt = flags_i.sf ^ flags_i.of;

  always_comb begin
    case (jmp_i)
      JC_ALW:  take_o = 1'b1;
      JC_LE:   take_o = lt | flags_i.zf;
      JC_LT:   take_o = lt;
      JC_EQ:   take_o = flags_i.zf;
      JC_NE:   take_o = ~flags_i.zf;
      JC_GE:   take_o = ~lt;
      JC_GT:   take_o = ~lt & ~flags_i.zf;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   alu_fn_i,
  input  logic         set_flags_i,
  input  logic [3:0]   jmp_fn_i,
  output logic [W-1:0] result_o,
  output logic         fn_err_o,
  output logic [2:0]   flags_o,
  output logic         take_o
);
  logic   of_n;
  logic   upd;
  flags_t f_d, f_q;

  alu_core #(.W(W)) u_core (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (alu_fn_i),
    .res_o (result_o),
    .of_o  (of_n),
    .err_o (fn_err_o)
  );

  assign upd = set_flags_i & ~fn_err_o;
  assign f_d = '{of: of_n, sf: result_o[W-1], zf: (result_o == '0)};

  flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (upd),
    .d_i    (f_d),
    .q_o    (f_q)
  );

  cond_eval u_cond (
    .flags_i (f_q),
    .jmp_i   (jmp_fn_i),
    .take_o  (take_o)
  );

  assign flags_o = f_q;

  // R4
  err_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_err_o |=> $stable(flags_o));

  // R5
  zf_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && !fn_err_o) |=> (flags_o[0] == ($past(result_o) == '0)));

  // R5
  sf_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && !fn_err_o) |=> (flags_o[1] == $past(result_o[W-1])));

  // R6
  logic_clears_of_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && (alu_fn_i == 4'd2 || alu_fn_i == 4'd3)) |=> !flags_o[2]);

  // R9
  jump_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_fn_i == 4'd0) |-> take_o);
endmodule

// File: tb/tb_alu_cc_unit.sv
`timescale 1ns/1ps
module tb_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  fn = '0;
  logic        setf = 1'b0;
  logic [3:0]  jf = '0;
  logic [31:0] res;
  logic        err;
  logic [2:0]  flags;
  logic        take;

  int n_chk = 0, n_fail = 0;
  logic [2:0] exp_flags = 3'b001;

  always #2 clk = ~clk;

  alu_cc_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .alu_fn_i(fn),
    .set_flags_i(setf), .jmp_fn_i(jf), .result_o(res), .fn_err_o(err),
    .flags_o(flags), .take_o(take)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_res(input logic [31:0] x, input logic [31:0] y, input logic [3:0] f);
    case (f)
      4'd0: return y + x;
      4'd1: return y - x;
      4'd2: return x & y;
      4'd3: return x ^ y;
      default: return '0;
    endcase
  endfunction

  function automatic logic [2:0] mdl_flags(input logic [31:0] x, input logic [31:0] y, input logic [3:0] f);
    logic [31:0] r;
    logic o;
    r = mdl_res(x, y, f);
    o = 1'b0;
    if (f == 4'd0) o = (x[31] == y[31]) && (r[31] != x[31]);
    if (f == 4'd1) o = (x[31] != y[31]) && (r[31] != y[31]);
    return {o, r[31], r == 32'd0};
  endfunction

  function automatic logic mdl_take(input logic [2:0] fl, input logic [3:0] j);
    logic o, s, z, l;
    {o, s, z} = fl;
    l = s ^ o;
    case (j)
      4'd0: return 1'b1;
      4'd1: return l | z;
      4'd2: return l;
      4'd3: return z;
      4'd4: return ~z;
      4'd5: return ~l;
      4'd6: return ~l & ~z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_jumps();
    for (int j = 0; j < 16; j++) begin
      jf = 4'(j);
      #0.05;
      chk("R9 take", {31'd0, take}, {31'd0, mdl_take(exp_flags, 4'(j))});
    end
  endtask

  task automatic step(input logic [31:0] x, input logic [31:0] y, input logic [3:0] f, input logic s);
    @(negedge clk);
    a = x; b = y; fn = f; setf = s;
    #1;
    case (f)
      4'd0: chk("R1 add", res, mdl_res(x, y, f));
      4'd1: chk("R2 sub", res, mdl_res(x, y, f));
      4'd2, 4'd3: chk("R3 logic", res, mdl_res(x, y, f));
      default: chk("R4 undefined result", res, 32'd0);
    endcase
    chk("R4 err", {31'd0, err}, {31'd0, (f > 4'd3)});
    if (s && f <= 4'd3) exp_flags = mdl_flags(x, y, f);
    @(posedge clk);
    #1;
    if (f > 4'd3)   chk("R4 flags kept", {29'd0, flags}, {29'd0, exp_flags});
    else if (!s)    chk("R7 flags hold", {29'd0, flags}, {29'd0, exp_flags});
    else if (f < 2) chk("R5 R6 flags arith", {29'd0, flags}, {29'd0, exp_flags});
    else            chk("R5 R6 flags logic", {29'd0, flags}, {29'd0, exp_flags});
    sweep_jumps();
  endtask

  localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                                        32'hffffffff, 32'h12345678, 32'ha5a5a5a5, 32'h5};

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    #3;
    chk("R8 reset flags", {29'd0, flags}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 flags after release", {29'd0, flags}, 32'd1);
    sweep_jumps();
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 8; k++)
        for (int f = 0; f < 4; f++)
          step(VALS[i], VALS[k], 4'(f), 1'b1);
    // R7: values that would change every flag, enable low
    step(32'h0, 32'h0, 4'd0, 1'b1);
    step(32'h7fffffff, 32'h1, 4'd0, 1'b0);
    step(32'h80000000, 32'h1, 4'd1, 1'b0);
    // R4: every undefined code with the enable high
    step(32'h7fffffff, 32'h1, 4'd0, 1'b1);
    for (int f = 4; f < 16; f++) step(32'h0, 32'h0, 4'(f), 1'b1);
    step(32'h1, 32'h1, 4'd1, 1'b1);
    for (int f = 4; f < 16; f++) step(32'hffffffff, 32'h1, 4'(f), 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule